// File: doc/BRIEF.md
# Pipelined Signed/Unsigned Integer Multiplier

This block multiplies two integer operands of a configurable width and returns their full double-width product after a fixed number of clock cycles. A separate control bit for each operand selects whether that operand is read as two's complement or as an unsigned number, so all four mixes of signedness are available on every cycle. A new operand pair may be presented on every cycle, and a valid flag moves down the pipeline beside the data so that the consumer knows which output cycles carry a result.

Inside the block, each operand is first converted to a magnitude and a sign. The magnitudes are cut into bytes, and every byte of one operand is multiplied by every byte of the other. These 16-bit partial products are placed at their byte offsets and added together in a tree whose levels are spread over the register stages. The sign is applied by one negation at the end. The two parameters are the operand width and the pipeline depth. There is no lane or parallelism parameter: SIMD use is obtained by placing several instances side by side.

Top module: `byteMul`

## Requirements
- R1: The parameters are the operand width `WIDTH` (default 64, a multiple of 8, at least 8) and the pipeline depth `DEPTH` (default 3, from 1 to 16). A setting outside these limits stops elaboration. `product` is `2*WIDTH` bits wide and carries the exact product for every width that can be built.
- R2: When `inValid` is high in a cycle, `outValid` is high and `product` holds that operation's result exactly `DEPTH` cycles later.
- R3: Operations may be presented on consecutive cycles with no gap, and each one produces its own correct result in order.
- R4: With `signA`=0 and `signB`=0, both operands are read as unsigned and `product` is their unsigned product.
- R5: With `signA`=1 and `signB`=1, both operands are read as two's complement and `product` is their exact two's-complement product, including the most negative value times itself. A nonzero result with differing operand signs has bit `2*WIDTH-1` set.
- R6: With exactly one sign control set, that operand is read as two's complement and the other as unsigned, and `product` is their exact two's-complement product. When the result is not negative, bit `2*WIDTH-1` is clear.
- R7: If either operand is zero, `product` is zero whatever the sign controls.
- R8: A synchronous reset (`rst` high at a rising edge) clears every valid stage. `outValid` is low from the first edge with reset high and stays low after reset until `DEPTH` cycles after the next accepted operation. Operations that were in flight are discarded.
- R9: `outValid` is low in every cycle that does not fall `DEPTH` cycles after a cycle with `inValid` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; clears the valid pipeline |
| inValid | input | 1 | The operands on `opA`/`opB` are to be multiplied this cycle |
| opA | input | WIDTH | First operand |
| opB | input | WIDTH | Second operand |
| signA | input | 1 | 1: `opA` is two's complement; 0: unsigned |
| signB | input | 1 | 1: `opB` is two's complement; 0: unsigned |
| outValid | output | 1 | `product` carries a result this cycle |
| product | output | 2*WIDTH | Full-width product |

## Verification
The bench builds four instances. An 8-bit, depth-2 instance is swept over all 65536 operand pairs, with the signedness mix rotating, so every byte product and every sign combination is exhausted. A 16-bit, depth-5 instance has more tree levels than it needs, which brings the pass-through register levels within reach. A 24-bit, depth-1 instance keeps the byte products unregistered and sums nine terms in a single level. A 64-bit, depth-3 instance is the default build and runs the corner operands (zero, one, two, all ones, the most positive value and the most negative value) in all four sign modes, together with random pairs. On every instance the bench inserts bubbles and applies a reset while operations are in flight, which checks that valid stays aligned with its data and that flushed operations never appear.

// File: rtl/mulPkg.sv
package mulPkg;

  // Upper bound on pipeline depth; sizes the strobe bundle.
  localparam int MAX_DEPTH = 16;

  // Per-stage load strobes from control to datapath.
  typedef struct packed {
    logic [MAX_DEPTH-1:0] stageLoad;
  } mulStrobes_t;

  // Smallest fan-in g >= 2 such that g**levels covers all terms.
  function automatic int groupSize(int terms, int levels);
    int g;
    int p;
    for (g = 2; g < terms; g++) begin
      p = 1;
      for (int k = 0; k < levels; k++) begin
        if (p < terms) p = p * g;
      end
      if (p >= terms) return g;
    end
    return (terms < 2) ? 2 : terms;
  endfunction

  // Number of live terms left after a given number of reduction levels.
  function automatic int levelCount(int terms, int g, int lvl);
    int c;
    c = terms;
    for (int k = 0; k < lvl; k++) c = (c + g - 1) / g;
    return c;
  endfunction

endpackage

// File: rtl/mulReduceStage.sv
module mulReduceStage #(
  parameter int PW      = 128,
  parameter int TERMS   = 64,
  parameter int GRP     = 8,
  parameter int OUT_CNT = 8,
  parameter bit FINAL   = 1'b0
) (
  input  logic          clk,
  input  logic          load,
  input  logic          negIn,
  input  logic [PW-1:0] termsIn [TERMS],
  output logic          negOut,
  output logic [PW-1:0] sumOut  [TERMS]
);

  logic [PW-1:0] sumD [TERMS];

  // Group-wise addition; only the last level applies the sign.
  always_comb begin
    for (int o = 0; o < TERMS; o++) begin
      sumD[o] = '0;
      if (o < OUT_CNT) begin
        for (int k = 0; k < GRP; k++) begin
          if (o * GRP + k < TERMS) sumD[o] = sumD[o] + termsIn[o * GRP + k];
        end
      end
    end
    if (FINAL && negIn) sumD[0] = -sumD[0];
  end

  // Data registers: no reset, loaded only when a valid op passes.
  always_ff @(posedge clk) begin
    if (load) begin
      negOut <= negIn;
      for (int o = 0; o < TERMS; o++) sumOut[o] <= sumD[o];
    end
  end

endmodule

// File: rtl/mulDatapath.sv
module mulDatapath
  import mulPkg::*;
#(
  parameter int WIDTH = 64,
  parameter int DEPTH = 3
) (
  input  logic               clk,
  input  mulStrobes_t        strobe,
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  input  logic               signA,
  input  logic               signB,
  output logic [2*WIDTH-1:0] product
);

  localparam int NB     = WIDTH / 8;
  localparam int TERMS  = NB * NB;
  localparam int PW     = 2 * WIDTH;
  localparam bit PP_REG = (DEPTH > 1);
  localparam int LEVELS = PP_REG ? DEPTH - 1 : 1;
  localparam int LOFF   = PP_REG ? 1 : 0;
  localparam int GRP    = groupSize(TERMS, LEVELS);

  // Front end: magnitude and sign of each operand.
  logic             negA, negB, negFront;
  logic [WIDTH-1:0] magA, magB;

  always_comb begin
    negA     = signA & opA[WIDTH-1];
    negB     = signB & opB[WIDTH-1];
    magA     = negA ? (~opA + 1'b1) : opA;
    magB     = negB ? (~opB + 1'b1) : opB;
    negFront = negA ^ negB;
  end

  // Byte-by-byte partial products.
  logic [15:0] ppComb [TERMS];
  logic [15:0] ppQ    [TERMS];
  logic        negPp;

  for (genvar i = 0; i < NB; i++) begin : g_ppRow
    for (genvar j = 0; j < NB; j++) begin : g_ppCol
      assign ppComb[i*NB+j] = 16'(magA[8*i +: 8]) * 16'(magB[8*j +: 8]);
    end
  end

  if (PP_REG) begin : g_ppReg
    always_ff @(posedge clk) begin
      if (strobe.stageLoad[0]) begin
        ppQ   <= ppComb;
        negPp <= negFront;
      end
    end
  end else begin : g_ppComb
    always_comb begin
      ppQ   = ppComb;
      negPp = negFront;
    end
  end

  // Place each partial product at its byte offset.
  logic [PW-1:0] termsBase [TERMS];

  for (genvar i = 0; i < NB; i++) begin : g_placeRow
    for (genvar j = 0; j < NB; j++) begin : g_placeCol
      assign termsBase[i*NB+j] = PW'(ppQ[i*NB+j]) << (8 * (i + j));
    end
  end

  // Adder-tree levels, one register boundary each.
  logic [PW-1:0] lvlVal [LEVELS][TERMS];
  logic          lvlNeg [LEVELS];

  for (genvar l = 0; l < LEVELS; l++) begin : g_level
    localparam int OUT_CNT = levelCount(TERMS, GRP, l + 1);
    if (l == 0) begin : g_first
      mulReduceStage #(
        .PW(PW), .TERMS(TERMS), .GRP(GRP), .OUT_CNT(OUT_CNT),
        .FINAL(LEVELS == 1)
      ) u_stage (
        .clk    (clk),
        .load   (strobe.stageLoad[LOFF]),
        .negIn  (negPp),
        .termsIn(termsBase),
        .negOut (lvlNeg[0]),
        .sumOut (lvlVal[0])
      );
    end else begin : g_next
      mulReduceStage #(
        .PW(PW), .TERMS(TERMS), .GRP(GRP), .OUT_CNT(OUT_CNT),
        .FINAL(l == LEVELS - 1)
      ) u_stage (
        .clk    (clk),
        .load   (strobe.stageLoad[l + LOFF]),
        .negIn  (lvlNeg[l-1]),
        .termsIn(lvlVal[l-1]),
        .negOut (lvlNeg[l]),
        .sumOut (lvlVal[l])
      );
    end
  end

  assign product = lvlVal[LEVELS-1][0];

  if (DEPTH < MAX_DEPTH) begin : g_spareStrobes
    logic unusedStrobes;
    assign unusedStrobes = ^strobe.stageLoad[MAX_DEPTH-1:DEPTH];
  end

endmodule

// File: rtl/mulCtrl.sv
module mulCtrl
  import mulPkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output mulStrobes_t strobe,
  output logic        outValid
);

  localparam int CW = $clog2(DEPTH + 1);

  logic [DEPTH-1:0] vld;

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else     vld <= DEPTH'({vld, inValid});
  end

  // Stage k loads when the op that is entering it is valid.
  always_comb begin
    strobe.stageLoad = MAX_DEPTH'(DEPTH'({vld, inValid}));
  end

  assign outValid = vld[DEPTH-1];

  // Run of consecutive idle input cycles, saturating at DEPTH.
  logic [CW-1:0] idleRun;

  always_ff @(posedge clk) begin
    if (rst || inValid)          idleRun <= '0;
    else if (idleRun < CW'(DEPTH)) idleRun <= idleRun + 1'b1;
  end

  AST_RESET_CLEARS_VALID: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !outValid);  // R8

  AST_IDLE_NO_OUTPUT: assert property (@(posedge clk) disable iff (rst)
    (idleRun >= CW'(DEPTH)) |-> !outValid);  // R9

endmodule

// File: rtl/byteMul.sv
module byteMul
  import mulPkg::*;
#(
  parameter int WIDTH = 64,
  parameter int DEPTH = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  input  logic               signA,
  input  logic               signB,
  output logic               outValid,
  output logic [2*WIDTH-1:0] product
);

  if (WIDTH < 8 || WIDTH % 8 != 0) begin : g_badWidth
    $error("byteMul: WIDTH must be a positive multiple of 8");
  end
  if (DEPTH < 1 || DEPTH > MAX_DEPTH) begin : g_badDepth
    $error("byteMul: DEPTH out of range");
  end

  mulStrobes_t strobe;

  mulCtrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .strobe  (strobe),
    .outValid(outValid)
  );

  mulDatapath #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_dp (
    .clk    (clk),
    .strobe (strobe),
    .opA    (opA),
    .opB    (opB),
    .signA  (signA),
    .signB  (signB),
    .product(product)
  );

  // Shadow of operand properties for result-level checks.
  logic inNeg, inZero, inClear;
  always_comb begin
    inZero  = (opA == '0) || (opB == '0);
    inNeg   = !inZero && ((signA & opA[WIDTH-1]) ^ (signB & opB[WIDTH-1]));
    inClear = !inNeg && (signA || signB);
  end

  logic [DEPTH-1:0] shV, shZero, shNeg, shClear;

  always_ff @(posedge clk) begin
    if (rst) shV <= '0;
    else     shV <= DEPTH'({shV, inValid});
    shZero  <= DEPTH'({shZero, inZero});
    shNeg   <= DEPTH'({shNeg, inNeg});
    shClear <= DEPTH'({shClear, inClear});
  end

  AST_VALID_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    outValid == shV[DEPTH-1]);  // R2

  AST_ZERO_RESULT: assert property (@(posedge clk) disable iff (rst)
    (outValid && shZero[DEPTH-1]) |-> (product == '0));  // R7

  AST_NEG_RESULT: assert property (@(posedge clk) disable iff (rst)
    (outValid && shNeg[DEPTH-1]) |-> product[2*WIDTH-1]);  // R5

  AST_NONNEG_RESULT: assert property (@(posedge clk) disable iff (rst)
    (outValid && shClear[DEPTH-1]) |-> !product[2*WIDTH-1]);  // R6

endmodule

// File: tb/byteMul_test.sv
module mulHarness #(
  parameter int    W       = 8,
  parameter int    D       = 2,
  parameter string PFX     = "w8",
  parameter int    RAND_N  = 0,
  parameter bit    EXHAUST = 1'b0
) (
  input  logic clk,
  output logic done,
  output int   nChecks,
  output int   nErrors
);

  logic           rst, inValid, signA, signB, outValid;
  logic [W-1:0]   opA, opB;
  logic [2*W-1:0] product;

  byteMul #(.WIDTH(W), .DEPTH(D)) uut (
    .clk(clk), .rst(rst), .inValid(inValid), .opA(opA), .opB(opB),
    .signA(signA), .signB(signB), .outValid(outValid), .product(product)
  );

  int           cyc = 0;
  int           dueQ [$];
  logic [127:0] expQ [$];
  string        tagQ [$];
  string        idleTag = "R9";

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [127:0] refMul(logic [63:0] x, logic [63:0] y, bit xs, bit ys);
    logic [127:0] ex, ey;
    ex = 128'(x[W-1:0]);
    ey = 128'(y[W-1:0]);
    if (xs && x[W-1]) ex = ex | ~((128'd1 << W) - 128'd1);
    if (ys && y[W-1]) ey = ey | ~((128'd1 << W) - 128'd1);
    return ex * ey;
  endfunction

  function automatic string modeTag(logic [63:0] x, logic [63:0] y, bit xs, bit ys);
    if (x[W-1:0] == '0 || y[W-1:0] == '0) return "R7";
    if (xs && ys)   return "R5";
    if (!xs && !ys) return "R4";
    return "R6";
  endfunction

  task automatic checkOut();
    nChecks++;
    if (dueQ.size() > 0 && dueQ[0] == cyc) begin
      if (outValid !== 1'b1 || product !== expQ[0][2*W-1:0]) begin
        nErrors++;
        $display("FAIL %s %s: outValid=%b product=%h expected outValid=1 product=%h",
                 PFX, tagQ[0], outValid, product, expQ[0][2*W-1:0]);
      end
      void'(dueQ.pop_front());
      void'(expQ.pop_front());
      void'(tagQ.pop_front());
    end else if (outValid !== 1'b0) begin
      nErrors++;
      $display("FAIL %s %s: outValid=%b expected 0", PFX, idleTag, outValid);
    end
  endtask

  task automatic step(bit v, logic [63:0] x, logic [63:0] y, bit xs, bit ys, string ph);
    @(negedge clk);
    checkOut();
    inValid = v;
    opA     = x[W-1:0];
    opB     = y[W-1:0];
    signA   = xs;
    signB   = ys;
    if (v) begin
      dueQ.push_back(cyc + D);
      expQ.push_back(refMul(x, y, xs, ys));
      tagQ.push_back({ph, "/", modeTag(x, y, xs, ys)});
    end
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic resetCheck();
    @(negedge clk);
    nChecks++;
    if (outValid !== 1'b0) begin
      nErrors++;
      $display("FAIL %s R8: outValid=%b expected 0 under reset", PFX, outValid);
    end
  endtask

  initial begin
    logic [63:0] ones, minV, maxV;
    logic [63:0] corner [6];
    done    = 1'b0;
    nChecks = 0;
    nErrors = 0;
    rst     = 1'b1;
    inValid = 1'b0;
    opA = '0; opB = '0; signA = 1'b0; signB = 1'b0;
    ones = {64{1'b1}} >> (64 - W);
    minV = 64'd1 << (W - 1);
    maxV = ones >> 1;
    corner[0] = 64'd0; corner[1] = 64'd1; corner[2] = 64'd2;
    corner[3] = ones;  corner[4] = minV;  corner[5] = maxV;

    // Reset state
    resetCheck();
    resetCheck();
    rst = 1'b0;

    // Corners, back to back, all four sign modes (R3)
    for (int m = 0; m < 4; m++)
      for (int i = 0; i < 6; i++)
        for (int j = 0; j < 6; j++)
          step(1'b1, corner[i], corner[j], m[0], m[1], "R3");

    // Bubbles: latency and idle output (R2, R9)
    for (int k = 0; k < 300; k++)
      step(($urandom() % 2) == 0, rnd64(), rnd64(), $urandom() % 2 == 0, $urandom() % 2 == 0, "R2");

    // Reset with operations in flight (R8)
    for (int k = 0; k < 4; k++) step(1'b1, rnd64(), rnd64(), 1'b1, 1'b0, "R3");
    @(negedge clk);
    checkOut();
    rst = 1'b1;
    inValid = 1'b0;
    dueQ.delete();
    expQ.delete();
    tagQ.delete();
    resetCheck();
    resetCheck();
    rst = 1'b0;
    idleTag = "R8";
    repeat (D + 2) step(1'b0, 64'd0, 64'd0, 1'b0, 1'b0, "R8");
    idleTag = "R9";

    // Sweep: exhaustive for the small build, random otherwise (R1)
    if (EXHAUST) begin
      for (int x = 0; x < (1 << W); x++)
        for (int y = 0; y < (1 << W); y++)
          step(1'b1, 64'(x), 64'(y), ((x + y) & 1) != 0, ((x + y) & 2) != 0, "R1");
    end else begin
      for (int k = 0; k < RAND_N; k++)
        step(1'b1, rnd64(), rnd64(), $urandom() % 2 == 0, $urandom() % 2 == 0, "R1");
    end

    repeat (D + 2) step(1'b0, 64'd0, 64'd0, 1'b0, 1'b0, "R9");
    done = 1'b1;
  end

endmodule

module byteMul_test;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic doneA, doneB, doneC, doneD;
  int   chkA, chkB, chkC, chkD, errA, errB, errC, errD;

  mulHarness #(.W(8),  .D(2), .PFX("w8d2"),  .RAND_N(0),    .EXHAUST(1'b1)) h8  (.clk(clk), .done(doneA), .nChecks(chkA), .nErrors(errA));
  mulHarness #(.W(16), .D(5), .PFX("w16d5"), .RAND_N(3000), .EXHAUST(1'b0)) h16 (.clk(clk), .done(doneB), .nChecks(chkB), .nErrors(errB));
  mulHarness #(.W(24), .D(1), .PFX("w24d1"), .RAND_N(3000), .EXHAUST(1'b0)) h24 (.clk(clk), .done(doneC), .nChecks(chkC), .nErrors(errC));
  mulHarness #(.W(64), .D(3), .PFX("w64d3"), .RAND_N(3000), .EXHAUST(1'b0)) h64 (.clk(clk), .done(doneD), .nChecks(chkD), .nErrors(errD));

  initial begin
    int waited;
    int totChecks;
    int totErrors;
    waited = 0;
    while (!(doneA && doneB && doneC && doneD) && waited < 150000) begin
      @(posedge clk);
      waited++;
    end
    #1;
    totChecks = chkA + chkB + chkC + chkD + 1;
    totErrors = errA + errB + errC + errD;
    if (!(doneA && doneB && doneC && doneD)) begin
      totErrors++;
      $display("FAIL watchdog R1-all: waited=%0d cycles expected completion", waited);
    end
    $display("Simulation finished: %0d checks, %0d errors", totChecks, totErrors);
    $finish;
  end

endmodule